// File: doc/BRIEF.md
# Per-Port Byte Rate Limiter

This block polices the traffic of one switch port by counting the bytes of every accepted packet inside a one-second window and comparing the running total against a programmed ceiling. The ceiling is written as a count of 32 kbps steps, and one step is 4000 bytes per second. Once the total goes past the ceiling, the block tells the port to refuse further packets until the window ends. At the end of each window all counts return to zero.

Two independent lanes are kept, one for high-priority and one for low-priority packets. When priority handling is turned off, every packet goes to the low lane. A build parameter selects receive or transmit use. In receive use the block also raises a flow-control request as the count approaches the ceiling, so that the link partner can be paused before any packet is lost. The size of that early margin depends on the programmed rate. Pause frame generation and packet storage belong to neighbouring blocks.

Top module: `byte_rate_limiter`

## Requirements
- R1: While reset is held and right after it is released, `blockLo`, `blockHi` and `fcReq` are low for any nonzero limit below the maximum step value, and every byte count is zero.
- R2: Each cycle with `acceptValid` high adds `acceptLen` to the count of its lane. The count is registered, so the block output reflects it from the cycle after the accepting edge. A lane blocks when its count is strictly greater than its step value times 4000. A count exactly equal to that product does not block.
- R3: The window lasts `CLK_HZ` cycles. The first clearing edge is the `CLK_HZ`-th rising edge after reset is released, and clearing repeats every `CLK_HZ` edges. A lane that blocks stays blocked until the clearing edge, and its count is zero after that edge.
- R4: A packet accepted on a clearing edge is not lost. Its length becomes the first content of the new window.
- R5: A step value of 0 blocks its lane at all times, even before any traffic.
- R6: The maximum step value (all ones, 4095 by default) means no limit: that lane never blocks and never asks for flow control.
- R7: In receive mode, with a step value from 1 to 3 (below 128 kbps), a lane asks for flow control once its count is at least the byte limit minus 2048.
- R8: In receive mode, with a step value of 4 or more (128 kbps or more), a lane asks for flow control once its count is at least the byte limit minus 8192, where the difference is floored at zero.
- R9: In transmit mode (`RX_MODE` = 0), `fcReq` is always low, while blocking works the same as in receive mode.
- R10: With `prioEn` high, a packet with `acceptHigh` = 1 goes to the high lane, which is limited by `limitHi` and drives `blockHi`. A packet with `acceptHigh` = 0 goes to the low lane, which is limited by `limitLo` and drives `blockLo`. Neither lane's traffic moves the other lane's output.
- R11: With `prioEn` low, all packets go to the low lane whatever `acceptHigh` says, `blockHi` equals `blockLo`, and `limitHi` has no effect.
- R12: `fcReq` is the OR of the flow-control requests of the lanes in use. The high lane counts only while `prioEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acceptValid | input | 1 | One-cycle strobe for each packet the port accepts |
| acceptLen | input | LEN_W | Byte length of the accepted packet |
| acceptHigh | input | 1 | 1 = high-priority packet |
| prioEn | input | 1 | 1 = separate high and low lanes |
| limitLo | input | LIMIT_W | Low-lane ceiling in 32 kbps steps |
| limitHi | input | LIMIT_W | High-lane ceiling in 32 kbps steps |
| blockLo | output | 1 | Refuse further low-priority packets |
| blockHi | output | 1 | Refuse further high-priority packets |
| fcReq | output | 1 | Early flow-control request (receive mode only) |

## Verification
The bench aims at the exact ceiling. It lands the count precisely on the step value times 4000 and then one small packet beyond it. A design that compares with greater-or-equal would block one packet too early. The bench also picks counts that fall between the two possible flow-control thresholds, so a design that chooses the wrong margin for the programmed rate would raise the request too early or too late. A packet is placed on the clearing edge itself, which catches a design whose window clear drops that packet. Other checks cover the zero and unlimited step values and a disabled high lane that is set to block, which show whether the unused lane or the special step values leak into the outputs.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int unsigned BYTES_PER_STEP  = 4000;
  localparam int unsigned FC_MARGIN_SMALL = 2048;
  localparam int unsigned FC_MARGIN_LARGE = 8192;
  localparam int unsigned FC_SPLIT_STEP   = 4;
  localparam int LANES   = 2;
  localparam int LANE_LO = 0;
  localparam int LANE_HI = 1;

  typedef struct packed {
    logic tick;
    logic addHi;
    logic addLo;
  } rlStrobes_t;
endpackage

// File: rtl/rl_control.sv
module rl_control
  import rl_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       acceptValid,
  input  logic       acceptHigh,
  input  logic       prioEn,
  output rlStrobes_t strobes
);
  localparam int TIMER_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(CLK_HZ - 1);

  logic [TIMER_W-1:0] timer;
  logic wrap;
  logic toHigh;

  assign wrap   = (timer == TIMER_LAST);
  assign toHigh = prioEn & acceptHigh;

  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else       timer <= wrap ? '0 : timer + 1'b1;
  end

  always_comb begin
    strobes.tick  = wrap;
    strobes.addHi = acceptValid & toHigh;
    strobes.addLo = acceptValid & ~toHigh;
  end
endmodule

// File: rtl/rl_datapath.sv
module rl_datapath
  import rl_pkg::*;
#(
  parameter int LIMIT_W = 12,
  parameter int LEN_W   = 11,
  parameter int CNT_W   = 25,
  parameter bit RX_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  rlStrobes_t         strobes,
  input  logic [LEN_W-1:0]   len,
  input  logic [LIMIT_W-1:0] stepLo,
  input  logic [LIMIT_W-1:0] stepHi,
  output logic [LANES-1:0]   laneBlock,
  output logic [LANES-1:0]   laneNear
);
  logic [LIMIT_W-1:0] stepVec [LANES];
  logic [LANES-1:0]   addVec;

  assign stepVec[LANE_LO] = stepLo;
  assign stepVec[LANE_HI] = stepHi;
  assign addVec[LANE_LO]  = strobes.addLo;
  assign addVec[LANE_HI]  = strobes.addHi;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [CNT_W-1:0] count, countNext, accum;
    logic [CNT_W-1:0] limitBytes, margin, threshold;
    logic [CNT_W:0]   sum;
    logic             unlimited, zeroLimit;

    assign limitBytes = CNT_W'(stepVec[g]) * CNT_W'(BYTES_PER_STEP);
    assign unlimited  = &stepVec[g];
    assign zeroLimit  = (stepVec[g] == '0);
    assign margin     = (stepVec[g] >= LIMIT_W'(FC_SPLIT_STEP)) ?
                        CNT_W'(FC_MARGIN_LARGE) : CNT_W'(FC_MARGIN_SMALL);
    assign threshold  = (limitBytes > margin) ? (limitBytes - margin) : '0;

    always_comb begin
      accum = strobes.tick ? '0 : count;
      sum   = {1'b0, accum} + (CNT_W+1)'(len);
      if (addVec[g]) countNext = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      else           countNext = accum;
    end

    always_ff @(posedge clk) begin
      if (!rstN) count <= '0;
      else       count <= countNext;
    end

    assign laneBlock[g] = !unlimited && (zeroLimit || (count > limitBytes));

    if (RX_MODE) begin : gRx
      assign laneNear[g] = !unlimited && (count >= threshold);
    end else begin : gTx
      assign laneNear[g] = 1'b0;
    end
  end
endmodule

// File: rtl/byte_rate_limiter.sv
module byte_rate_limiter
  import rl_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int          LIMIT_W = 12,
  parameter int          LEN_W   = 11,
  parameter bit          RX_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               acceptValid,
  input  logic [LEN_W-1:0]   acceptLen,
  input  logic               acceptHigh,
  input  logic               prioEn,
  input  logic [LIMIT_W-1:0] limitLo,
  input  logic [LIMIT_W-1:0] limitHi,
  output logic               blockLo,
  output logic               blockHi,
  output logic               fcReq
);
  localparam int unsigned MAX_BYTES = ((2 ** LIMIT_W) - 1) * BYTES_PER_STEP;
  localparam int          CNT_W     = $clog2(MAX_BYTES + 1) + 1;

  rlStrobes_t       strobes;
  logic [LANES-1:0] laneBlock;
  logic [LANES-1:0] laneNear;

  rl_control #(.CLK_HZ(CLK_HZ)) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .acceptValid(acceptValid),
    .acceptHigh (acceptHigh),
    .prioEn     (prioEn),
    .strobes    (strobes)
  );

  rl_datapath #(
    .LIMIT_W(LIMIT_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .RX_MODE(RX_MODE)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .len      (acceptLen),
    .stepLo   (limitLo),
    .stepHi   (limitHi),
    .laneBlock(laneBlock),
    .laneNear (laneNear)
  );

  assign blockLo = laneBlock[LANE_LO];
  assign blockHi = prioEn ? laneBlock[LANE_HI] : laneBlock[LANE_LO];
  assign fcReq   = laneNear[LANE_LO] | (prioEn & laneNear[LANE_HI]);
endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
  parameter int LIMIT_W = 12,
  parameter bit RX_MODE = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               prioEn,
  input logic [LIMIT_W-1:0] limitLo,
  input logic               blockLo,
  input logic               blockHi,
  input logic               fcReq,
  input logic               tick,
  input logic               addLo
);
  // R2
  block_needs_traffic_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockLo) |-> ($past(addLo) || !$stable(limitLo)));

  // R3
  block_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockLo && !tick) |=> (blockLo || !$stable(limitLo)));

  // R3
  window_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !addLo) |=> (!blockLo || !$stable(limitLo) || (limitLo == '0)));

  // R5
  zero_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limitLo == '0) |-> blockLo);

  // R6
  unlimited_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&limitLo) |-> !blockLo);

  // R11
  mirror_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !prioEn |-> (blockHi == blockLo));

  if (!RX_MODE) begin : gTxChk
    // R9
    tx_no_fc_chk: assert property (@(posedge clk) disable iff (!rstN)
      !fcReq);
  end
endmodule

bind byte_rate_limiter rl_checker #(.LIMIT_W(LIMIT_W), .RX_MODE(RX_MODE)) uChecker (
  .clk    (clk),
  .rstN   (rstN),
  .prioEn (prioEn),
  .limitLo(limitLo),
  .blockLo(blockLo),
  .blockHi(blockHi),
  .fcReq  (fcReq),
  .tick   (strobes.tick),
  .addLo  (strobes.addLo)
);

// File: tb/byte_rate_limiter_test.sv
module byte_rate_limiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 1000;
  localparam int LIMIT_W    = 12;
  localparam int LEN_W      = 11;
  localparam logic [LIMIT_W-1:0] UNLIM = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic acceptValid = 1'b0;
  logic [LEN_W-1:0] acceptLen = '0;
  logic acceptHigh = 1'b0;
  logic prioEn = 1'b0;
  logic [LIMIT_W-1:0] limitLo = 12'd5;
  logic [LIMIT_W-1:0] limitHi = 12'd5;
  logic blockLo, blockHi, fcReq;
  logic txBlockLo, txBlockHi, txFcReq;

  int checks = 0;
  int fails  = 0;
  int edgeCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  byte_rate_limiter #(.CLK_HZ(WINDOW), .LIMIT_W(LIMIT_W), .LEN_W(LEN_W), .RX_MODE(1'b1)) uut (
    .clk(clk), .rstN(rstN), .acceptValid(acceptValid), .acceptLen(acceptLen),
    .acceptHigh(acceptHigh), .prioEn(prioEn), .limitLo(limitLo), .limitHi(limitHi),
    .blockLo(blockLo), .blockHi(blockHi), .fcReq(fcReq));

  byte_rate_limiter #(.CLK_HZ(WINDOW), .LIMIT_W(LIMIT_W), .LEN_W(LEN_W), .RX_MODE(1'b0)) uutTx (
    .clk(clk), .rstN(rstN), .acceptValid(acceptValid), .acceptLen(acceptLen),
    .acceptHigh(acceptHigh), .prioEn(prioEn), .limitLo(limitLo), .limitHi(limitHi),
    .blockLo(txBlockLo), .blockHi(txBlockHi), .fcReq(txFcReq));

  task automatic check(input logic actual, input logic expected, input string what);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, actual, expected);
    end
  endtask

  task automatic setCfg(input logic pe, input logic [LIMIT_W-1:0] lo, input logic [LIMIT_W-1:0] hi);
    @(negedge clk);
    prioEn = pe; limitLo = lo; limitHi = hi;
    #1;
  endtask

  task automatic sendPkt(input int len, input logic hi);
    @(negedge clk);
    acceptValid = 1'b1; acceptLen = LEN_W'(len); acceptHigh = hi;
    @(negedge clk);
    acceptValid = 1'b0;
    #1;
  endtask

  task automatic waitPhase(input int phase);
    forever begin
      @(posedge clk);
      #1;
      if (edgeCnt % WINDOW == phase) break;
    end
  endtask

  task automatic testReset();
    check(blockLo, 1'b0, "R1 blockLo in reset");
    check(fcReq, 1'b0, "R1 fcReq in reset");
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    check(blockLo, 1'b0, "R1 blockLo after reset");
    check(blockHi, 1'b0, "R1 blockHi after reset");
    check(fcReq, 1'b0, "R1 fcReq after reset");
  endtask

  task automatic testCountBlock();
    setCfg(1'b0, 12'd1, UNLIM);
    waitPhase(0);
    sendPkt(1500, 1'b0);
    check(blockLo, 1'b0, "R2 1500 of 4000 not blocked");
    check(fcReq, 1'b0, "R7 1500 below 1952");
    sendPkt(1500, 1'b0);
    check(fcReq, 1'b1, "R7 3000 above 1952");
    check(blockLo, 1'b0, "R2 3000 not blocked");
    sendPkt(1000, 1'b0);
    check(blockLo, 1'b0, "R2 count equal to limit not blocked");
    sendPkt(64, 1'b0);
    check(blockLo, 1'b1, "R2 count above limit blocks");
    check(txBlockLo, 1'b1, "R9 transmit mode blocks the same");
    waitPhase(WINDOW - 2);
    check(blockLo, 1'b1, "R3 block held until window end");
    waitPhase(0);
    check(blockLo, 1'b0, "R3 block released after clear");
    check(fcReq, 1'b0, "R3 count zero after clear");
  endtask

  task automatic testMargins();
    setCfg(1'b0, 12'd3, UNLIM);
    waitPhase(0);
    for (int i = 0; i < 4; i++) sendPkt(2000, 1'b0);
    check(fcReq, 1'b0, "R7 step 3 uses 2048 margin at 8000");
    setCfg(1'b0, 12'd4, UNLIM);
    check(fcReq, 1'b1, "R8 step 4 uses 8192 margin at 8000");
    check(blockLo, 1'b0, "R8 8000 of 16000 not blocked");
  endtask

  task automatic testZeroAndTx();
    setCfg(1'b0, 12'd0, UNLIM);
    waitPhase(0);
    check(blockLo, 1'b1, "R5 step 0 blocks without traffic");
    check(fcReq, 1'b1, "R5 step 0 asks for flow control");
    check(txBlockLo, 1'b1, "R9 transmit step 0 blocks");
    check(txFcReq, 1'b0, "R9 transmit never asks for flow control");
  endtask

  task automatic testUnlimited();
    setCfg(1'b0, UNLIM, UNLIM);
    waitPhase(0);
    for (int i = 0; i < 12; i++) sendPkt(2047, 1'b0);
    check(blockLo, 1'b0, "R6 max step never blocks");
    check(fcReq, 1'b0, "R6 max step no flow control");
  endtask

  task automatic testPriority();
    setCfg(1'b1, 12'd2, 12'd1);
    waitPhase(0);
    sendPkt(2047, 1'b1);
    sendPkt(2047, 1'b1);
    check(blockHi, 1'b1, "R10 high lane above 4000 blocks");
    check(blockLo, 1'b0, "R10 low lane untouched by high traffic");
    check(fcReq, 1'b1, "R12 high lane near raises fcReq");
    sendPkt(2047, 1'b0);
    sendPkt(2047, 1'b0);
    check(blockLo, 1'b0, "R10 low 4094 of 8000 not blocked");
    check(blockHi, 1'b1, "R10 high stays blocked");
  endtask

  task automatic testNoPriority();
    setCfg(1'b0, UNLIM, 12'd0);
    waitPhase(0);
    check(blockHi, 1'b0, "R11 hi limit ignored, mirrors low");
    check(fcReq, 1'b0, "R12 unused high lane gives no fcReq");
    setCfg(1'b0, 12'd1, 12'd0);
    sendPkt(2047, 1'b1);
    sendPkt(2047, 1'b1);
    check(blockLo, 1'b1, "R11 high-flagged packets count in low lane");
    check(blockHi, 1'b1, "R11 blockHi mirrors blockLo");
  endtask

  task automatic testBoundary();
    setCfg(1'b0, 12'd1, UNLIM);
    waitPhase(0);
    sendPkt(2047, 1'b0);
    sendPkt(2047, 1'b0);
    check(blockLo, 1'b1, "R4 setup blocked before boundary");
    waitPhase(WINDOW - 1);
    sendPkt(2047, 1'b0);
    check(blockLo, 1'b0, "R4 old window cleared");
    check(fcReq, 1'b1, "R4 boundary packet counted in new window");
    sendPkt(2047, 1'b0);
    check(blockLo, 1'b1, "R4 boundary packet plus one exceeds limit");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testCountBlock();
    testMargins();
    testZeroAndTx();
    testUnlimited();
    testPriority();
    testNoPriority();
    testBoundary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule